// File: doc/BRIEF.md
# Two-Word Control Port Decoder

This block sits behind the control port of a video display processor. Every 16-bit word written to that port is either a complete register write or one half of a two-word access command. The block tells the two apart from a pending flag and the top two bits of the word. It holds the register file. It assembles the 32-bit command and decodes from it three things: an access target code, a 17-bit access address and a DMA request.

The bits of the decoded fields are scattered across both command words. Each data-port access advances the address by the step held in a register. A carry out of the low 16 address bits flips the top address bit.

The block also shows the target that the next data-port access will use. While a command is half written, that target is decoded from the latched words rather than taken from the stored target.

Top module: `ctl_word_decoder`

## Requirements
- R1: After reset every register reads 0, no command is pending, the stored target code, wide flag and address are 0, and `dma_start` is low.
- R2: With no command pending, a control word whose bits [15:14] are 2'b10 writes bits [7:0] into the register numbered by bits [12:8]. From the next cycle that value reads back on `reg_val` when `reg_sel` selects that register.
- R3: A register write to a number of NUM_REGS or more changes no register. Such numbers always read back as 0.
- R4: A register write sets the stored target code and wide flag to 0 and leaves the address unchanged.
- R5: With no command pending, a control word whose bits [15:14] are not 2'b10 is kept as the upper command half and sets the pending flag. The stored target does not change.
- R6: While a command is pending, any control word is taken as the lower command half, even if its bits [15:14] are 2'b10. This clears the pending flag and loads the stored target with code = {lower[5:4], upper[15:14]} and address = {lower[2], lower[1:0], upper[13:0]}.
- R7: When a command is decoded with code 4'b0001 while register 1 bit 7 is set, the wide flag is set. Any other code, or that bit clear, gives wide = 0.
- R8: A lower command half with bit 7 set raises `dma_start` for exactly the one cycle after the write, provided register 1 bit 4 is set. If register 1 bit 4 is clear, bit 7 keeps its previously latched value, which is 0, and no DMA start follows.
- R9: While a command is pending, the `eff_*` outputs show the target decoded from the latched halves, with the lower half kept from the last command. A data-port access then completes that decode and clears the pending flag.
- R10: Each data-port access adds the value of register 15 to address bits [15:0], modulo 2^16. A carry out of bit 15 toggles address bit 16. The code and the wide flag do not change.
- R11: A data-port access in the same cycle as a control-port write is ignored. Only the control write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control-port write strobe |
| ctl_data | input | 16 | Control-port write data |
| dat_acc | input | 1 | Data-port access strobe (read or write) |
| reg_sel | input | 5 | Register readback select |
| reg_val | output | REG_W | Selected register value |
| cmd_pending | output | 1 | First command half latched, second awaited |
| dma_start | output | 1 | One-cycle DMA request pulse |
| acc_code | output | 4 | Stored access target code |
| acc_wide | output | 1 | Stored 128 KB layout flag |
| acc_addr | output | 17 | Stored access address |
| eff_code | output | 4 | Target code the next data access uses |
| eff_wide | output | 1 | Wide flag the next data access uses |
| eff_addr | output | 17 | Address the next data access uses |

## Verification
The bench builds the block with its default parameters: 24 registers, 8-bit values, register 1 as the mode register and register 15 as the step register. With 24 registers, the 5-bit register field can name numbers 24 to 31, so the ignored-write path is reachable. An 8-bit step lets a handful of accesses carry out of address bit 15 and flip bit 16. Random words exercise both the mode bits (wide layout and DMA gate) and the collision of the two ports.

// File: rtl/cpd_pkg.sv
`timescale 1ns/1ps
package cpd_pkg;

  localparam int CTL_W     = 16;
  localparam int SEL_W     = 5;
  localparam int ADDR_W    = 17;
  localparam int ADDR_LO_W = 16;

  localparam logic [3:0] CODE_VRAM_WR = 4'b0001;

  typedef struct packed {
    logic              wide;
    logic [3:0]        code;
    logic [ADDR_W-1:0] addr;
  } target_t;

  // hi: upper command half; lo_code: lower half bits [5:4];
  // lo_addr: lower half bits [2:0]
  function automatic target_t decode_cmd(input logic [CTL_W-1:0] hi,
                                         input logic [1:0]       lo_code,
                                         input logic [2:0]       lo_addr,
                                         input logic             wide_en);
    target_t t;
    t.code = {lo_code, hi[15:14]};
    t.addr = {lo_addr[2], lo_addr[1:0], hi[13:0]};
    t.wide = wide_en && (t.code == CODE_VRAM_WR);
    return t;
  endfunction

endpackage

// File: rtl/cpd_regfile.sv
`timescale 1ns/1ps
module cpd_regfile #(
  parameter int NUM_REGS = 24,
  parameter int REG_W    = 8,
  parameter int SEL_W    = 5,
  parameter int MODE_IDX = 1,
  parameter int STEP_IDX = 15,
  parameter int WIDE_BIT = 7,
  parameter int GATE_BIT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [REG_W-1:0] wr_val,
  input  logic [SEL_W-1:0] rd_sel,
  output logic [REG_W-1:0] rd_val,
  output logic             mode_wide,
  output logic             mode_gate,
  output logic [REG_W-1:0] step_val
);

  localparam int FLAT_W = NUM_REGS * REG_W;

  logic [FLAT_W-1:0]   flat;
  logic [NUM_REGS-1:0] hit;

  for (genvar g = 0; g < NUM_REGS; g++) begin : gen_reg
    logic [REG_W-1:0] q;
    logic [REG_W-1:0] d;

    assign hit[g] = wr_en && (wr_sel == SEL_W'(g));

    always_comb begin
      d = q;
      if (hit[g]) d = wr_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= '0;
      else if (hit[g]) q <= d;
    end

    assign flat[g*REG_W +: REG_W] = q;
  end

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rd_sel == SEL_W'(i)) rd_val = flat[i*REG_W +: REG_W];
    end
  end

  assign mode_wide = flat[MODE_IDX*REG_W + WIDE_BIT];
  assign mode_gate = flat[MODE_IDX*REG_W + GATE_BIT];
  assign step_val  = flat[STEP_IDX*REG_W +: REG_W];

  AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(flat)); // R2
  AST_REG_HIGH_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (int'(wr_sel) >= NUM_REGS)) |=> $stable(flat)); // R3
  AST_REG_ONE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit)); // R2

endmodule

// File: rtl/cpd_cmd_latch.sv
`timescale 1ns/1ps
module cpd_cmd_latch
  import cpd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_data,
  input  logic             dat_acc,
  input  logic             dma_gate,
  input  logic             wide_en,
  output logic             reg_wr,
  output logic             decode_now,
  output logic             pending_q,
  output logic             dma_start_q,
  output target_t          dec_nx,
  output target_t          dec_q
);

  logic [2*CTL_W-1:0] cmd_q, cmd_d;
  logic               pending_d, dma_d, cmd_en;
  logic               reg_form, first_wr, second_wr, flush;
  logic [CTL_W-1:0]   low_gated;

  assign reg_form  = (ctl_data[15:14] == 2'b10);
  assign reg_wr    = ctl_wr && !pending_q && reg_form;
  assign first_wr  = ctl_wr && !pending_q && !reg_form;
  assign second_wr = ctl_wr && pending_q;
  assign flush     = dat_acc && !ctl_wr && pending_q;
  assign decode_now = second_wr || flush;

  // DMA bit of the lower half keeps its latched value when the gate is off
  assign low_gated = {ctl_data[15:8], (dma_gate ? ctl_data[7] : cmd_q[7]),
                      ctl_data[6:0]};

  assign cmd_en = first_wr || second_wr || dma_start_q;

  always_comb begin
    cmd_d = cmd_q;
    if (dma_start_q) cmd_d[7] = 1'b0;
    if (first_wr)  cmd_d[2*CTL_W-1:CTL_W] = ctl_data;
    if (second_wr) cmd_d[CTL_W-1:0] = low_gated;
  end

  always_comb begin
    pending_d = pending_q;
    if (first_wr)        pending_d = 1'b1;
    else if (decode_now) pending_d = 1'b0;
  end

  assign dma_d = second_wr && low_gated[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmd_q <= '0;
    else if (cmd_en) cmd_q <= cmd_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q   <= 1'b0;
      dma_start_q <= 1'b0;
    end else begin
      pending_q   <= pending_d;
      dma_start_q <= dma_d;
    end
  end

  assign dec_nx = decode_cmd(cmd_d[2*CTL_W-1:CTL_W], cmd_d[5:4], cmd_d[2:0], wide_en);
  assign dec_q  = decode_cmd(cmd_q[2*CTL_W-1:CTL_W], cmd_q[5:4], cmd_q[2:0], wide_en);

  AST_FIRST_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    first_wr |=> pending_q); // R5
  AST_DECODE_CLEARS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    decode_now |=> !pending_q); // R6
  AST_DMA_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    dma_start_q |=> !dma_start_q); // R8
  AST_DMA_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_start_q) |-> ($past(dma_gate) && $past(pending_q))); // R8
  AST_REG_NOT_WHILE_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> !pending_q); // R6

endmodule

// File: rtl/cpd_addr_step.sv
`timescale 1ns/1ps
module cpd_addr_step
  import cpd_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  target_t          load_tgt,
  input  logic             step,
  input  logic             clr,
  input  logic [REG_W-1:0] step_val,
  output target_t          tgt_q
);

  target_t            base, tgt_d;
  logic [ADDR_LO_W:0] sum;
  logic               en;

  assign en   = load || step || clr;
  assign base = load ? load_tgt : tgt_q;
  assign sum  = {1'b0, base.addr[ADDR_LO_W-1:0]} + (ADDR_LO_W+1)'(step_val);

  always_comb begin
    tgt_d = base;
    if (clr) begin
      tgt_d.code = '0;
      tgt_d.wide = 1'b0;
    end
    if (step) begin
      tgt_d.addr[ADDR_LO_W-1:0] = sum[ADDR_LO_W-1:0];
      tgt_d.addr[ADDR_LO_W]     = base.addr[ADDR_LO_W] ^ sum[ADDR_LO_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  tgt_q <= '0;
    else if (en) tgt_q <= tgt_d;
  end

  AST_STEP_ZERO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && (step_val == '0)) |=> $stable(tgt_q)); // R10
  AST_STEP_KEEPS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> ($stable(tgt_q.code) && $stable(tgt_q.wide))); // R10
  AST_CLR_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> ((tgt_q.code == 4'd0) && !tgt_q.wide && $stable(tgt_q.addr))); // R4
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(load || step || clr) |=> $stable(tgt_q)); // R11

endmodule

// File: rtl/ctl_word_decoder.sv
`timescale 1ns/1ps
module ctl_word_decoder
  import cpd_pkg::*;
#(
  parameter int NUM_REGS = 24,
  parameter int REG_W    = 8,
  parameter int MODE_REG = 1,
  parameter int STEP_REG = 15,
  parameter int WIDE_BIT = 7,
  parameter int GATE_BIT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic [15:0]       ctl_data,
  input  logic              dat_acc,
  input  logic [4:0]        reg_sel,
  output logic [REG_W-1:0]  reg_val,
  output logic              cmd_pending,
  output logic              dma_start,
  output logic [3:0]        acc_code,
  output logic              acc_wide,
  output logic [16:0]       acc_addr,
  output logic [3:0]        eff_code,
  output logic              eff_wide,
  output logic [16:0]       eff_addr
);

  logic             reg_wr, decode_now, pending_q, dma_start_q;
  logic             mode_wide, mode_gate, step_en;
  logic [REG_W-1:0] step_val;
  target_t          dec_nx, dec_q, tgt_q, eff;

  cpd_regfile #(
    .NUM_REGS (NUM_REGS),
    .REG_W    (REG_W),
    .SEL_W    (SEL_W),
    .MODE_IDX (MODE_REG),
    .STEP_IDX (STEP_REG),
    .WIDE_BIT (WIDE_BIT),
    .GATE_BIT (GATE_BIT)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (reg_wr),
    .wr_sel    (ctl_data[12:8]),
    .wr_val    (REG_W'(ctl_data[7:0])),
    .rd_sel    (reg_sel),
    .rd_val    (reg_val),
    .mode_wide (mode_wide),
    .mode_gate (mode_gate),
    .step_val  (step_val)
  );

  cpd_cmd_latch u_cmd (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl_wr      (ctl_wr),
    .ctl_data    (ctl_data),
    .dat_acc     (dat_acc),
    .dma_gate    (mode_gate),
    .wide_en     (mode_wide),
    .reg_wr      (reg_wr),
    .decode_now  (decode_now),
    .pending_q   (pending_q),
    .dma_start_q (dma_start_q),
    .dec_nx      (dec_nx),
    .dec_q       (dec_q)
  );

  assign step_en = dat_acc && !ctl_wr;

  cpd_addr_step #(
    .REG_W (REG_W)
  ) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (decode_now),
    .load_tgt (dec_nx),
    .step     (step_en),
    .clr      (reg_wr),
    .step_val (step_val),
    .tgt_q    (tgt_q)
  );

  assign eff = pending_q ? dec_q : tgt_q;

  assign cmd_pending = pending_q;
  assign dma_start   = dma_start_q;
  assign acc_code    = tgt_q.code;
  assign acc_wide    = tgt_q.wide;
  assign acc_addr    = tgt_q.addr;
  assign eff_code    = eff.code;
  assign eff_wide    = eff.wide;
  assign eff_addr    = eff.addr;

  AST_WIDE_ONLY_VRAM: assert property (@(posedge clk) disable iff (!rst_n)
    acc_wide |-> (acc_code == CODE_VRAM_WR)); // R7
  AST_FLUSH_LOADS_EFF: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_q && dat_acc && !ctl_wr && (step_val == '0)) |=>
      (acc_addr == $past(eff_addr) && acc_code == $past(eff_code))); // R9

endmodule

// File: tb/test_ctl_word_decoder.sv
`timescale 1ns/1ps
module test_ctl_word_decoder;

  localparam int NREG = 24;

  logic        clk, rst_n, ctl_wr, dat_acc;
  logic [15:0] ctl_data;
  logic [4:0]  reg_sel;
  logic [7:0]  reg_val;
  logic        cmd_pending, dma_start, acc_wide, eff_wide;
  logic [3:0]  acc_code, eff_code;
  logic [16:0] acc_addr, eff_addr;

  ctl_word_decoder i_ctl_word_decoder (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_data(ctl_data),
    .dat_acc(dat_acc), .reg_sel(reg_sel), .reg_val(reg_val),
    .cmd_pending(cmd_pending), .dma_start(dma_start),
    .acc_code(acc_code), .acc_wide(acc_wide), .acc_addr(acc_addr),
    .eff_code(eff_code), .eff_wide(eff_wide), .eff_addr(eff_addr)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  finished = 0;

  // reference model state
  logic [7:0]  m_regs [32];
  logic        m_pend, m_wide, m_dma;
  logic [31:0] m_cmd;
  logic [3:0]  m_code;
  logic [16:0] m_addr;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] f_code(input logic [31:0] c);
    return {c[5], c[4], c[31], c[30]};
  endfunction
  function automatic logic [16:0] f_addr(input logic [31:0] c);
    return {c[2], c[1], c[0], c[29:16]};
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 32; i++) m_regs[i] = 8'h00;
    m_pend = 0; m_wide = 0; m_dma = 0; m_cmd = '0; m_code = '0; m_addr = '0;
  endtask

  task automatic model_step(input bit cw, input logic [15:0] w, input bit da);
    logic [16:0] lo;
    m_dma = 0;
    if (cw) begin
      if (!m_pend && w[15:14] == 2'b10) begin
        if (int'(w[12:8]) < NREG) m_regs[w[12:8]] = w[7:0];
        m_code = 4'd0; m_wide = 0;
      end else if (!m_pend) begin
        m_cmd[31:16] = w; m_pend = 1;
      end else begin
        m_cmd[15:0] = {w[15:8], (m_regs[1][4] ? w[7] : 1'b0), w[6:0]};
        m_pend = 0;
        m_code = f_code(m_cmd); m_addr = f_addr(m_cmd);
        m_wide = (m_code == 4'b0001) && m_regs[1][7];
        m_dma  = m_regs[1][4] && w[7];
      end
    end else if (da) begin
      if (m_pend) begin
        m_pend = 0;
        m_code = f_code(m_cmd); m_addr = f_addr(m_cmd);
        m_wide = (m_code == 4'b0001) && m_regs[1][7];
      end
      lo = {1'b0, m_addr[15:0]} + {9'd0, m_regs[15]};
      m_addr = {m_addr[16] ^ lo[16], lo[15:0]};
    end
  endtask

  task automatic check_all();
    logic [3:0] ec; logic [16:0] ea; logic ew;
    chk("R5 R6 pending", cmd_pending, m_pend);
    chk("R6 code", acc_code, m_code);
    chk("R7 wide", acc_wide, m_wide);
    chk("R10 addr", acc_addr, m_addr);
    chk("R8 dma", dma_start, m_dma);
    chk("R2 readback", reg_val, m_regs[reg_sel]);
    if (m_pend) begin
      ec = f_code(m_cmd); ea = f_addr(m_cmd); ew = (ec == 4'b0001) && m_regs[1][7];
    end else begin
      ec = m_code; ea = m_addr; ew = m_wide;
    end
    chk("R9 eff code", eff_code, ec);
    chk("R9 eff addr", eff_addr, ea);
    chk("R9 eff wide", eff_wide, ew);
  endtask

  // called at a negedge; returns at the following negedge after checking
  task automatic cyc(input bit cw, input logic [15:0] w, input bit da);
    ctl_wr = cw; ctl_data = w; dat_acc = da;
    reg_sel = 5'($urandom % 32);
    @(posedge clk);
    model_step(cw, w, da);
    @(negedge clk);
    ctl_wr = 0; dat_acc = 0;
    check_all();
  endtask

  task automatic idle();
    cyc(1'b0, 16'h0000, 1'b0);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; ctl_wr = 0; dat_acc = 0; ctl_data = '0; reg_sel = '0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk("R1 pending", cmd_pending, 0);
    chk("R1 addr", acc_addr, 0);
    chk("R1 code", acc_code, 0);
    chk("R1 dma", dma_start, 0);
    for (int i = 0; i < 32; i++) begin
      reg_sel = 5'(i); #1;
      chk("R1 reg", reg_val, 0);
    end

    // R2: step register 15 = 2, mode register 1 = wide + gate
    cyc(1, 16'h8F02, 0);
    cyc(1, 16'h8190, 0);
    reg_sel = 5'd15; #1; chk("R2 reg15", reg_val, 8'h02);

    // R5/R6/R7: VRAM write at 0x1234, wide layout
    cyc(1, 16'h5234, 0);
    chk("R5 pending", cmd_pending, 1);
    chk("R5 target kept", acc_addr, 0);
    cyc(1, 16'h0000, 0);
    chk("R6 addr", acc_addr, 17'h01234);
    chk("R7 wide", acc_wide, 1);
    chk("R7 code", acc_code, 4'b0001);
    cyc(0, 16'h0000, 1);
    chk("R10 step", acc_addr, 17'h01236);

    // R10: carry from bit 15 flips bit 16
    cyc(1, 16'h8F20, 0);
    cyc(1, 16'h7FF0, 0);
    cyc(1, 16'h0003, 0);
    chk("R6 addr hi", acc_addr, 17'h0FFF0);
    cyc(0, 16'h0000, 1);
    chk("R10 carry", acc_addr, 17'h10010);
    cyc(0, 16'h0000, 1);
    chk("R10 after carry", acc_addr, 17'h10030);

    // R8: DMA with the gate set, then with it clear
    cyc(1, 16'h4000, 0);
    cyc(1, 16'h0080, 0);
    chk("R8 dma pulse", dma_start, 1);
    idle();
    chk("R8 dma one cycle", dma_start, 0);
    cyc(1, 16'h8180, 0);
    cyc(1, 16'h4000, 0);
    cyc(1, 16'h0080, 0);
    chk("R8 dma blocked", dma_start, 0);

    // R9: pending then data access
    cyc(1, 16'h4010, 0);
    chk("R9 eff while pending", eff_addr, 17'h00010);
    cyc(0, 16'h0000, 1);
    chk("R9 pending cleared", cmd_pending, 0);
    chk("R9 decoded and stepped", acc_addr, 17'h00030);

    // R11: collision of both ports
    cyc(1, 16'h4100, 1);
    chk("R11 addr unchanged", acc_addr, 17'h00030);
    chk("R11 pending", cmd_pending, 1);
    // R6: register-form word while pending is a command half
    cyc(1, 16'h8F05, 0);
    reg_sel = 5'd15; #1;
    chk("R6 not a reg write", reg_val, 8'h20);
    chk("R6 pending clear", cmd_pending, 0);

    // R4: register write clears code, keeps address
    cyc(1, 16'h4200, 0);
    cyc(1, 16'h0010, 0);
    chk("R4 pre code", acc_code, 4'b0101);
    cyc(1, 16'h8233, 0);
    chk("R4 code cleared", acc_code, 0);
    chk("R4 addr kept", acc_addr, 17'h00200);

    // R3: write to register 25 is ignored
    cyc(1, 16'h9955, 0);
    for (int i = 0; i < 32; i++) begin
      reg_sel = 5'(i); #1;
      chk("R3 regs unchanged", reg_val, m_regs[i]);
    end

    // random mix
    for (int k = 0; k < 4000; k++) begin
      int r;
      logic [15:0] w;
      r = int'($urandom % 100);
      if ($urandom % 2 == 0)
        w = {2'b10, 1'b0, 5'($urandom % 32), 8'($urandom)};
      else
        w = 16'($urandom);
      if (r < 35)      cyc(1, w, 0);
      else if (r < 65) cyc(0, w, 1);
      else if (r < 72) cyc(1, w, 1);
      else             idle();
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule